// File: doc/BRIEF.md
# Slot-Timed Egress Packet Sender

This block drives one egress port of a router that holds each packet for a fixed number of time slots. A scheduler gives it descriptors. Each descriptor carries a buffer pointer, the lag value to stamp into the packet, and the slot in which the packet must leave. The sender fetches the packet from buffer memory straight away, over a simple one-request-at-a-time read port. It then parks the header word and releases it only when the global slot timer opens the chosen slot.

As the header word goes out, the block rewrites it. The 4-bit hop counter in bits 63:60 is lowered by one, and the 5-bit lag field in bits 59:55 is replaced by the descriptor's lag. The remaining words stream out unchanged, and the final word carries a last flag. On the cycle the header leaves, the block also emits a departure log record, which a collector further down the chip turns into measurement packets.

The slot timer is external. It supplies a start-of-slot pulse, the slot number and a free-running time count. The block accepts one descriptor while another packet is being handled, and applies backpressure beyond that.

Top module: `timed_sender`

## Requirements
- R1: After reset, tx_valid, tx_last, log_valid and rd_req are low, and desc_ready is high.
- R2: A descriptor is taken on a clock edge where desc_valid and desc_ready are both high. One descriptor can wait while a packet is in progress. While that waiting slot is occupied, desc_ready is low.
- R3: For each packet the block first reads address ptr. The low LEN_W bits of the returned word give the packet length in words, which must be at least 1. It then reads the packet words from ptr+1 upward. rd_req is a one-cycle pulse, and a new request is issued only after the previous response (rd_valid) has been seen.
- R4: The header word appears on tx_valid/tx_data in the cycle after the clock edge at which slot_tick is high and slot_num equals the descriptor's slot. No word of that packet appears earlier.
- R5: Output header bits 63:60 equal the stored hop count minus one, modulo 16, so a hop count of 0 becomes 15.
- R6: Output header bits 59:55 equal the descriptor lag. Bits 54:0 are passed through unchanged, which includes the packet ID in bits 11:0.
- R7: Words 2 to len are emitted in buffer order with their data unchanged. tx_last is high on word len only, so a one-word packet has tx_last set on its header.
- R8: log_valid pulses together with the header word. log_rec is {ID[11:0], now_time[18:0] at the launch edge, ptr[18:0], new hop[3:0], lag[4:0], PORT_NUM[1:0]}, with the ID in the MSBs.
- R9: Packets leave in descriptor order, each one in its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | High on the first cycle of each slot |
| slot_num | input | SLOT_W | Current slot number |
| now_time | input | TIME_W | Free-running time count |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_ptr | input | PTR_W | Buffer pointer of the packet |
| desc_lag | input | LAG_W | Lag value to stamp |
| desc_slot | input | SLOT_W | Departure slot |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | PTR_W | Read address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 64 | Read response data |
| tx_valid | output | 1 | Output word valid |
| tx_data | output | 64 | Output word |
| tx_last | output | 1 | Final word of packet |
| log_valid | output | 1 | Departure record valid |
| log_rec | output | LOG_W | Departure record |

## Verification
The main function is exercised with three patterns. The first is a three-word packet whose header has a nonzero hop count and an old lag. It separates exact slot gating and the field rewrite from pass-through of the body and the bit positions of the log record. The second is a one-word packet with hop count zero and the largest lag. It shows modulo-16 wrap, a full lag overwrite, and tx_last on a header. The third is a burst of three descriptors for consecutive slots. It shows the waiting register, backpressure, in-order release and per-slot launch timing.

// File: rtl/timed_sender.sv
`timescale 1ns/1ps
module timed_sender #(
  parameter int PTR_W = 19,
  parameter int LAG_W = 5,
  parameter int HOP_W = 4,
  parameter int ID_W = 12,
  parameter int TIME_W = 19,
  parameter int SLOT_W = 8,
  parameter int LEN_W = 8,
  parameter int PORT_W = 2,
  parameter logic [PORT_W-1:0] PORT_NUM = '0,
  localparam int LOG_W = ID_W + TIME_W + PTR_W + HOP_W + LAG_W + PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_tick,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [TIME_W-1:0] now_time,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [PTR_W-1:0]  desc_ptr,
  input  logic [LAG_W-1:0]  desc_lag,
  input  logic [SLOT_W-1:0] desc_slot,
  output logic              rd_req,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic              rd_valid,
  input  logic [63:0]       rd_data,
  output logic              tx_valid,
  output logic [63:0]       tx_data,
  output logic              tx_last,
  output logic              log_valid,
  output logic [LOG_W-1:0]  log_rec
);
  localparam int HOP_LSB = 64 - HOP_W;
  localparam int LAG_LSB = HOP_LSB - LAG_W;

  typedef enum logic [2:0] {S_IDLE, S_LEN, S_HDR, S_ARM, S_SEND} st_t;
  st_t st;

  logic              hold_v;
  logic [PTR_W-1:0]  hold_ptr, cur_ptr;
  logic [LAG_W-1:0]  hold_lag, cur_lag;
  logic [SLOT_W-1:0] hold_slot, cur_slot;
  logic [LEN_W-1:0]  len, sent;
  logic [63:0]       hdr;
  logic              launch;

  assign desc_ready = !hold_v;
  assign launch = (st == S_ARM) && slot_tick && (slot_num == cur_slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      hold_v <= 1'b0;
      hold_ptr <= '0; hold_lag <= '0; hold_slot <= '0;
      cur_ptr <= '0; cur_lag <= '0; cur_slot <= '0;
      len <= '0; sent <= '0; hdr <= '0;
      rd_req <= 1'b0; rd_addr <= '0;
      tx_valid <= 1'b0; tx_data <= '0; tx_last <= 1'b0;
      log_valid <= 1'b0; log_rec <= '0;
    end else begin
      rd_req <= 1'b0;
      tx_valid <= 1'b0;
      tx_last <= 1'b0;
      log_valid <= 1'b0;
      if (desc_valid && desc_ready) begin
        hold_v <= 1'b1;
        hold_ptr <= desc_ptr;
        hold_lag <= desc_lag;
        hold_slot <= desc_slot;
      end
      case (st)
        S_IDLE: if (hold_v) begin
          hold_v <= 1'b0;
          cur_ptr <= hold_ptr;
          cur_lag <= hold_lag;
          cur_slot <= hold_slot;
          rd_req <= 1'b1;
          rd_addr <= hold_ptr;
          st <= S_LEN;
        end
        S_LEN: if (rd_valid) begin
          len <= rd_data[LEN_W-1:0];
          rd_req <= 1'b1;
          rd_addr <= cur_ptr + PTR_W'(1);
          st <= S_HDR;
        end
        S_HDR: if (rd_valid) begin
          hdr <= {rd_data[63:HOP_LSB] - HOP_W'(1), cur_lag, rd_data[LAG_LSB-1:0]};
          st <= S_ARM;
        end
        S_ARM: if (launch) begin
          tx_valid <= 1'b1;
          tx_data <= hdr;
          tx_last <= (len <= LEN_W'(1));
          log_valid <= 1'b1;
          log_rec <= {hdr[ID_W-1:0], now_time, cur_ptr, hdr[63:HOP_LSB], cur_lag, PORT_NUM};
          sent <= LEN_W'(1);
          if (len <= LEN_W'(1)) st <= S_IDLE;
          else begin
            rd_req <= 1'b1;
            rd_addr <= cur_ptr + PTR_W'(2);
            st <= S_SEND;
          end
        end
        S_SEND: if (rd_valid) begin
          tx_valid <= 1'b1;
          tx_data <= rd_data;
          sent <= sent + LEN_W'(1);
          if (sent + LEN_W'(1) == len) begin
            tx_last <= 1'b1;
            st <= S_IDLE;
          end else begin
            rd_req <= 1'b1;
            rd_addr <= rd_addr + PTR_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module timed_sender_chk (
  input logic clk,
  input logic rst_n,
  input logic slot_tick,
  input logic rd_req,
  input logic rd_valid,
  input logic tx_valid,
  input logic tx_last,
  input logic log_valid
);
  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_launch_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> $past(slot_tick));
  assert_body_from_memory_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !log_valid) |-> $past(rd_valid));
  assert_last_in_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  assert_log_with_header_R8: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> tx_valid);
endmodule

bind timed_sender timed_sender_chk chk_i (.*);

// File: tb/timed_sender_tb_top.sv
`timescale 1ns/1ps
module timed_sender_tb_top;
  localparam int SLOT = 1524;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_tick = 1'b1;
  logic [7:0] slot_num = '0;
  logic [18:0] now_time = '0;
  logic desc_valid = 1'b0, desc_ready;
  logic [18:0] desc_ptr = '0;
  logic [4:0] desc_lag = '0;
  logic [7:0] desc_slot = '0;
  logic rd_req, rd_valid = 1'b0;
  logic [18:0] rd_addr;
  logic [63:0] rd_data = '0;
  logic tx_valid, tx_last, log_valid;
  logic [63:0] tx_data;
  logic [60:0] log_rec;

  always #4 clk = ~clk;

  timed_sender #(.PORT_NUM(2'd2)) dut_i (.*);

  logic [63:0] mem [0:255];
  int t = 0, nchk = 0, nfail = 0;
  int ntx = 0, nlog = 0;
  int tx_t [0:15];
  logic [63:0] tx_d [0:15];
  logic tx_l [0:15];
  logic [60:0] lg [0:15];

  initial forever begin
    @(posedge clk);
    rd_valid <= rd_req;
    rd_data <= mem[rd_addr[7:0]];
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && tx_valid && ntx < 16) begin
      tx_t[ntx] = t; tx_d[ntx] = tx_data; tx_l[ntx] = tx_last; ntx++;
    end
    if (rst_n && log_valid && nlog < 16) begin
      lg[nlog] = log_rec; nlog++;
    end
    t++;
    slot_tick = (t % SLOT == 0);
    slot_num = 8'(t / SLOT);
    now_time = 19'(t);
  end

  task automatic check(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] rewrite(input logic [63:0] w, input logic [4:0] lag);
    return {w[63:60] - 4'd1, lag, w[54:0]};
  endfunction

  task automatic put_desc(input int ptr, input int lag, input int slot);
    do @(negedge clk); while (!desc_ready);
    desc_valid = 1'b1; desc_ptr = 19'(ptr); desc_lag = 5'(lag); desc_slot = 8'(slot);
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic wait_until(input int tt);
    while (t < tt) @(negedge clk);
  endtask

  task automatic test_reset;
    @(negedge clk);
    check(tx_valid == 0 && tx_last == 0, "R1 tx idle", {62'd0, tx_valid, tx_last}, 64'd0);
    check(log_valid == 0, "R1 log idle", 64'(log_valid), 64'd0);
    check(rd_req == 0, "R1 no read", 64'(rd_req), 64'd0);
    check(desc_ready == 1, "R1 ready", 64'(desc_ready), 64'd1);
  endtask

  task automatic test_basic;
    logic [63:0] h;
    h = {4'd5, 5'd7, 43'h5A5_A5A5_A5A5, 12'h2A5};
    mem[16] = 64'd3; mem[17] = h;
    mem[18] = 64'h1111_2222_3333_4444; mem[19] = 64'hDEAD_BEEF_0BAD_F00D;
    ntx = 0; nlog = 0;
    put_desc(16, 3, 2);
    wait_until(2 * SLOT + 20);
    check(ntx == 3, "R7 word count", 64'(ntx), 64'd3);
    check(tx_t[0] == 2 * SLOT, "R4 launch cycle", 64'(tx_t[0]), 64'(2 * SLOT));
    check(tx_d[0][63:60] == 4'd4, "R5 hop decrement", 64'(tx_d[0][63:60]), 64'd4);
    check(tx_d[0] == rewrite(h, 5'd3), "R6 header rewrite", tx_d[0], rewrite(h, 5'd3));
    check(tx_d[1] == mem[18] && tx_d[2] == mem[19], "R3 R7 body words", tx_d[2], mem[19]);
    check({tx_l[0], tx_l[1], tx_l[2]} == 3'b001, "R7 last flag", 64'({tx_l[0], tx_l[1], tx_l[2]}), 64'b001);
    check(nlog == 1, "R8 log count", 64'(nlog), 64'd1);
    check(lg[0] == {12'h2A5, 19'(2 * SLOT), 19'd16, 4'd4, 5'd3, 2'd2}, "R8 log record",
          64'(lg[0]), 64'({12'h2A5, 19'(2 * SLOT), 19'd16, 4'd4, 5'd3, 2'd2}));
  endtask

  task automatic test_wrap;
    logic [63:0] h;
    h = {4'd0, 5'd0, 43'h7FF_0000_FFFF, 12'h001};
    mem[32] = 64'd1; mem[33] = h;
    ntx = 0; nlog = 0;
    put_desc(32, 31, 4);
    wait_until(4 * SLOT + 20);
    check(ntx == 1 && tx_t[0] == 4 * SLOT, "R4 single word launch", 64'(tx_t[0]), 64'(4 * SLOT));
    check(tx_d[0][63:60] == 4'd15, "R5 hop wrap", 64'(tx_d[0][63:60]), 64'd15);
    check(tx_d[0] == rewrite(h, 5'd31), "R6 max lag", tx_d[0], rewrite(h, 5'd31));
    check(tx_l[0] == 1'b1, "R7 last on header", 64'(tx_l[0]), 64'd1);
    check(lg[0][10:2] == {4'd15, 5'd31}, "R8 log hop lag", 64'(lg[0][10:2]), 64'({4'd15, 5'd31}));
  endtask

  task automatic test_queue;
    mem[48] = 64'd2; mem[49] = {4'd9, 5'd0, 43'd0, 12'h00A}; mem[50] = 64'hA0;
    mem[64] = 64'd2; mem[65] = {4'd9, 5'd0, 43'd0, 12'h00B}; mem[66] = 64'hB0;
    mem[80] = 64'd1; mem[81] = {4'd9, 5'd0, 43'd0, 12'h00C};
    wait_until(5 * SLOT + 10);
    ntx = 0; nlog = 0;
    put_desc(48, 1, 6);
    put_desc(64, 2, 7);
    check(desc_ready == 1'b0, "R2 backpressure", 64'(desc_ready), 64'd0);
    repeat (5) @(negedge clk);
    check(desc_ready == 1'b0, "R2 ready held low", 64'(desc_ready), 64'd0);
    put_desc(80, 0, 8);
    wait_until(8 * SLOT + 20);
    check(ntx == 5, "R9 word total", 64'(ntx), 64'd5);
    check(tx_t[0] == 6 * SLOT && tx_t[2] == 7 * SLOT && tx_t[4] == 8 * SLOT,
          "R9 per-slot launch", 64'(tx_t[4]), 64'(8 * SLOT));
    check(tx_d[0][11:0] == 12'h00A && tx_d[2][11:0] == 12'h00B && tx_d[4][11:0] == 12'h00C,
          "R9 order", 64'(tx_d[4][11:0]), 64'h00C);
    check(tx_d[1] == 64'hA0 && tx_d[3] == 64'hB0, "R7 queued bodies", tx_d[3], 64'hB0);
    check(tx_d[2][59:55] == 5'd2, "R6 queued lag", 64'(tx_d[2][59:55]), 64'd2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 64'(i) * 64'h0101_0101_0101_0101;
    repeat (4) @(negedge clk);
    test_reset;
    rst_n = 1'b1;
    test_reset;
    test_basic;
    test_wrap;
    test_queue;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule